// File: doc/BRIEF.md
# Reset-Time Configuration Loader

This block fills a system control register with one byte fetched from a fixed boot address every time the external reset input goes from low to high. The level of the TEST pin at that moment picks where the byte comes from: the internal boot ROM or the external bus on the multifunction pins. The block issues a single-byte read on a simple request/acknowledge memory port. It keeps the CPU held until the byte has arrived and been stored.

The stored byte is decoded into four things: which program storage is selected, whether the multifunction pins run in bus mode or normal mode, and the enables for internal RAM and for the internal CPU. The same byte also sets the length of the reset-out pulse that follows an internal reset request. A power-on flag makes the first pulse after power-up short when TEST is high.

Top module: `cfg_boot_loader`

## Requirements
- R1: While `rstN` is low, and right after it is released with `extRstN` low, `cpuHold`=1, `memReq`=0, `rstOut`=0 and `cfgByte`=0x00.
- R2: Each low-to-high transition of `extRstN` produces exactly one read request with `memAddr`=0x00FFF3. `memReq` stays high until the cycle in which `memAck` is seen, and drops in the cycle after it.
- R3: `memSrcExt` equals the TEST pin level at the start of the fetch (0 = internal boot ROM, 1 = external bus) and stays constant while the request is pending.
- R4: The byte returned with `memAck` is stored in the register and shown on `cfgByte`. `cpuHold` stays 1 while `extRstN` is low and until that byte is stored, then drops to 0.
- R5: `storageSel` encoding: bit2=0 gives 2 (external bus); bit2=1 with bit3=1 gives 1 (internal flash); bit2=1 with bit3=0 gives 0 (boot ROM).
- R6: `busMode` (1 = bus mode, 0 = normal mode): bit4=1 gives 0. Bit4=0 with bit6=0 gives 1. Bit4=0 with bit6=1 follows the live TEST pin inverted, so TEST=0 gives bus mode and TEST=1 gives normal mode.
- R7: `ramEn` is bit1 of the register and `cpuEn` is bit0 of the register.
- R8: With TEST=1 at the request, after the first pulse since power-on, a pulse on `intRstReq` drives `rstOut` high for 4095 cycles if bit7=1 and for 16 cycles if bit7=0.
- R9: With TEST=0 at the request, every reset-out pulse lasts 4095 cycles whatever bit7 holds.
- R10: The first reset-out pulse after power-on with TEST=1 lasts 16 cycles even when bit7=1.
- R11: A request on `intRstReq` while `rstOut` is high is ignored. The running pulse keeps its length and no second pulse follows.
- R12: Code 0xFF decodes to internal flash, normal mode, RAM and CPU enabled. Code 0xAB decodes to external bus storage, bus mode, RAM and CPU enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| extRstN | input | 1 | External reset input, asynchronous, active low |
| testPin | input | 1 | TEST pin level |
| intRstReq | input | 1 | Internal reset request, starts a reset-out pulse |
| memReq | output | 1 | Boot byte read request |
| memAddr | output | 24 | Read address |
| memSrcExt | output | 1 | Fetch source, 1 = external bus, 0 = boot ROM |
| memAck | input | 1 | Read data valid |
| memData | input | 8 | Read data |
| cpuHold | output | 1 | Keeps the CPU in reset |
| cfgByte | output | 8 | Stored control byte |
| storageSel | output | 2 | Program storage: 0 boot ROM, 1 flash, 2 external |
| busMode | output | 1 | Multifunction pins in bus mode |
| ramEn | output | 1 | Internal RAM enable |
| cpuEn | output | 1 | Internal CPU enable |
| rstOut | output | 1 | Reset-out pulse, active high |

## Verification
Five control bytes are loaded, each with a chosen TEST level. 0xFF and 0xAB cover the two standard codes. 0x5C gives flash with both enables off. 0x43 exercises the TEST-driven pin toggle, and the bench flips TEST afterwards to see bus mode follow it. 0x06 gives boot ROM and fixed bus mode. Between these loads, reset-out pulses are requested under every mix of TEST level, bit7 and power-on history, which separates the 16-cycle rule from the 4095-cycle rule. One of these pulses gets a second request in the middle of it, to show that the second request is dropped.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  typedef enum logic [1:0] {ST_WAIT, ST_FETCH, ST_RUN} fetch_state_e;

  localparam logic [1:0] SEL_BOOT  = 2'd0;
  localparam logic [1:0] SEL_FLASH = 2'd1;
  localparam logic [1:0] SEL_EXT   = 2'd2;

  localparam int BIT_LONG   = 7;
  localparam int BIT_TOGGLE = 6;
  localparam int BIT_MODE   = 4;
  localparam int BIT_FLASH  = 3;
  localparam int BIT_INTMEM = 2;
  localparam int BIT_RAM    = 1;
  localparam int BIT_CPU    = 0;

  typedef struct packed {
    logic loadCfg;
    logic startPulse;
    logic pulseLong;
  } dp_strobe_t;
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extRstN,
  input  logic       testPin,
  input  logic       intRstReq,
  input  logic       memAck,
  input  logic       pulseBusy,
  input  logic       longBit,
  output dp_strobe_t strobe,
  output logic       memReq,
  output logic       memSrcExt,
  output logic       cpuHold
);
  logic [1:0] syncQ;
  logic syncPrev, rstSync, riseDet;
  fetch_state_e state, stateNext;
  logic srcQ, powerOn, busyPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      syncPrev <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], extRstN};
      syncPrev <= syncQ[1];
    end
  end

  assign rstSync = syncQ[1];
  assign riseDet = syncQ[1] & ~syncPrev;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAIT:  if (riseDet) stateNext = ST_FETCH;
      ST_FETCH: if (!rstSync) stateNext = ST_WAIT;
                else if (memAck) stateNext = ST_RUN;
      ST_RUN:   if (!rstSync) stateNext = ST_WAIT;
      default:  stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_WAIT;
      srcQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT && riseDet) srcQ <= testPin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerOn <= 1'b1;
      busyPrev <= 1'b0;
    end else begin
      busyPrev <= pulseBusy;
      if (busyPrev && !pulseBusy) powerOn <= 1'b0;
    end
  end

  assign memReq    = (state == ST_FETCH);
  assign memSrcExt = srcQ;
  assign cpuHold   = (state != ST_RUN);

  always_comb begin
    strobe.loadCfg    = (state == ST_FETCH) && memAck && rstSync;
    strobe.startPulse = intRstReq && !pulseBusy;
    strobe.pulseLong  = !testPin || (!powerOn && longBit);
  end

  // R2: a pending request is held until acknowledged
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && rstSync) |=> memReq);
  // R3: the fetch source does not move during a request
  p_src_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> $stable(memSrcExt));
  // R4: the CPU is released only after an acknowledged fetch
  p_hold_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHold) |-> $past(memAck));
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_boot_pkg::*;
#(
  parameter int LONG_LEN  = 4095,
  parameter int SHORT_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strobe,
  input  logic       testPin,
  input  logic [7:0] memData,
  output logic [7:0] cfgByte,
  output logic [1:0] storageSel,
  output logic       busMode,
  output logic       ramEn,
  output logic       cpuEn,
  output logic       rstOut
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] SHORT_CNT = CNT_W'(SHORT_LEN);

  logic [7:0] cfgReg;
  logic [CNT_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (strobe.loadCfg) cfgReg <= memData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (strobe.startPulse) pulseCnt <= strobe.pulseLong ? LONG_CNT : SHORT_CNT;
    else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
  end

  assign rstOut  = (pulseCnt != '0);
  assign cfgByte = cfgReg;
  assign ramEn   = cfgReg[BIT_RAM];
  assign cpuEn   = cfgReg[BIT_CPU];

  always_comb begin
    if (!cfgReg[BIT_INTMEM]) storageSel = SEL_EXT;
    else if (cfgReg[BIT_FLASH]) storageSel = SEL_FLASH;
    else storageSel = SEL_BOOT;
  end

  always_comb begin
    if (cfgReg[BIT_MODE]) busMode = 1'b0;
    else if (!cfgReg[BIT_TOGGLE]) busMode = 1'b1;
    else busMode = !testPin;
  end

  // R4: a load strobe captures the returned byte
  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |=> (cfgReg == $past(memData)));
  // R11: a new pulse is only started when none is running
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startPulse |-> !rstOut);
  // R11: a running pulse is not cut short
  p_pulse_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rstOut && pulseCnt > 1) |=> rstOut);
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int          LONG_LEN  = 4095,
  parameter int          SHORT_LEN = 16,
  parameter logic [23:0] BOOT_ADDR = 24'h00FFF3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extRstN,
  input  logic        testPin,
  input  logic        intRstReq,
  output logic        memReq,
  output logic [23:0] memAddr,
  output logic        memSrcExt,
  input  logic        memAck,
  input  logic [7:0]  memData,
  output logic        cpuHold,
  output logic [7:0]  cfgByte,
  output logic [1:0]  storageSel,
  output logic        busMode,
  output logic        ramEn,
  output logic        cpuEn,
  output logic        rstOut
);
  dp_strobe_t strobe;

  assign memAddr = BOOT_ADDR;

  cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extRstN(extRstN), .testPin(testPin),
    .intRstReq(intRstReq), .memAck(memAck), .pulseBusy(rstOut),
    .longBit(cfgByte[BIT_LONG]), .strobe(strobe), .memReq(memReq),
    .memSrcExt(memSrcExt), .cpuHold(cpuHold)
  );

  cfg_datapath #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .testPin(testPin),
    .memData(memData), .cfgByte(cfgByte), .storageSel(storageSel),
    .busMode(busMode), .ramEn(ramEn), .cpuEn(cpuEn), .rstOut(rstOut)
  );
endmodule

// File: tb/sim_cfg_boot_loader.sv
module sim_cfg_boot_loader;
  logic clk = 1'b0;
  logic rstN, extRstN, testPin, intRstReq, memAck;
  logic [7:0] memData;
  logic memReq, memSrcExt, cpuHold, busMode, ramEn, cpuEn, rstOut;
  logic [23:0] memAddr;
  logic [7:0] cfgByte;
  logic [1:0] storageSel;

  int errors = 0;
  int checks = 0;
  int reqCount = 0;
  int fetchCount = 0;
  int runLen = 0;
  logic [7:0] nextData = 8'h00;
  logic [8:0] cfgQ[$];
  int lenQ[$];

  always #4 clk = ~clk;

  cfg_boot_loader u0 (
    .clk(clk), .rstN(rstN), .extRstN(extRstN), .testPin(testPin),
    .intRstReq(intRstReq), .memReq(memReq), .memAddr(memAddr),
    .memSrcExt(memSrcExt), .memAck(memAck), .memData(memData),
    .cpuHold(cpuHold), .cfgByte(cfgByte), .storageSel(storageSel),
    .busMode(busMode), .ramEn(ramEn), .cpuEn(cpuEn), .rstOut(rstOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expDecode(input logic [7:0] b, input logic t);
    logic [1:0] sel;
    logic bus;
    sel = !b[2] ? 2'd2 : (b[3] ? 2'd1 : 2'd0);
    bus = b[4] ? 1'b0 : (!b[6] ? 1'b1 : !t);
    return {sel, bus, b[1], b[0]};
  endfunction

  // memory model: checks address/source and answers after a delay
  initial begin
    memAck = 1'b0;
    memData = 8'h00;
    forever begin
      @(negedge clk);
      if (memReq) begin
        reqCount++;
        chk(memAddr == 24'h00FFF3, "R2 addr", memAddr, 24'h00FFF3);
        chk(memSrcExt == testPin, "R3 source", memSrcExt, testPin);
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(memReq == 1'b1, "R2 req held", memReq, 1);
          chk(cpuHold == 1'b1, "R4 hold during fetch", cpuHold, 1);
        end
        memAck = 1'b1;
        memData = nextData;
        @(negedge clk);
        memAck = 1'b0;
        memData = 8'h00;
        chk(memReq == 1'b0, "R2 single request", memReq, 0);
      end
    end
  end

  // configuration monitor: compares on release of the CPU
  initial begin
    logic prevHold;
    logic [8:0] item;
    logic [4:0] exp;
    prevHold = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN && prevHold && !cpuHold) begin
        if (cfgQ.size() == 0) chk(1'b0, "R4 unexpected load", cfgByte, 0);
        else begin
          item = cfgQ.pop_front();
          exp = expDecode(item[7:0], testPin);
          chk(cfgByte == item[7:0], "R4 byte", cfgByte, item[7:0]);
          chk(storageSel == exp[4:3], "R5 storage", storageSel, exp[4:3]);
          chk(busMode == exp[2], "R6 pin mode", busMode, exp[2]);
          chk({ramEn, cpuEn} == exp[1:0], "R7 enables", {ramEn, cpuEn}, exp[1:0]);
        end
      end
      prevHold = cpuHold;
    end
  end

  // pulse monitor: measures each reset-out pulse
  initial begin
    int expLen;
    forever begin
      @(negedge clk);
      if (rstOut) runLen++;
      else if (runLen > 0) begin
        if (lenQ.size() == 0) chk(1'b0, "R11 extra pulse", runLen, 0);
        else begin
          expLen = lenQ.pop_front();
          chk(runLen == expLen, "R8/R9/R10 pulse length", runLen, expLen);
        end
        runLen = 0;
      end
    end
  end

  task automatic doFetch(input logic [7:0] val, input logic t);
    @(negedge clk);
    extRstN = 1'b0;
    testPin = t;
    nextData = val;
    repeat (4) @(negedge clk);
    chk(cpuHold == 1'b1, "R4 hold in reset", cpuHold, 1);
    cfgQ.push_back({t, val});
    fetchCount++;
    extRstN = 1'b1;
    while (cpuHold) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic doPulse(input logic t, input int expLen, input bit extraReq);
    @(negedge clk);
    testPin = t;
    intRstReq = 1'b1;
    lenQ.push_back(expLen);
    @(negedge clk);
    intRstReq = 1'b0;
    if (extraReq) begin
      repeat (5) @(negedge clk);
      intRstReq = 1'b1;
      @(negedge clk);
      intRstReq = 1'b0;
    end
    while (rstOut) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    extRstN = 1'b0;
    testPin = 1'b0;
    intRstReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(cpuHold && !memReq && !rstOut && cfgByte == 8'h00, "R1 in reset",
        {cpuHold, memReq, rstOut, cfgByte}, {1'b1, 1'b0, 1'b0, 8'h00});
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpuHold && !memReq && !rstOut && cfgByte == 8'h00, "R1 after release",
        {cpuHold, memReq, rstOut, cfgByte}, {1'b1, 1'b0, 1'b0, 8'h00});

    doFetch(8'hFF, 1'b0);               // R12 stand-alone flash, R3 source 0
    chk(storageSel == 2'd1 && !busMode && ramEn && cpuEn, "R12 code FF",
        {storageSel, busMode, ramEn, cpuEn}, 5'b01011);
    doPulse(1'b1, 16, 1'b0);            // R10 first pulse short
    doPulse(1'b1, 4095, 1'b0);          // R8 long after first
    doFetch(8'hAB, 1'b1);               // R12 external bus, R3 source 1
    chk(storageSel == 2'd2 && busMode && ramEn && cpuEn, "R12 code AB",
        {storageSel, busMode, ramEn, cpuEn}, 5'b10111);
    doFetch(8'h5C, 1'b1);               // R5 flash, R7 both off
    doPulse(1'b1, 16, 1'b0);            // R8 short with bit7 clear
    doPulse(1'b0, 4095, 1'b0);          // R9 TEST low always long
    doPulse(1'b1, 16, 1'b1);            // R11 extra request ignored
    repeat (20) @(negedge clk);
    chk(runLen == 0 && lenQ.size() == 0 && !rstOut, "R11 no second pulse",
        runLen, 0);
    doFetch(8'h43, 1'b1);               // R6 toggle, TEST high -> normal
    @(negedge clk);
    testPin = 1'b0;
    @(negedge clk);
    chk(busMode == 1'b1, "R6 toggle to bus mode", busMode, 1);
    chk(storageSel == 2'd2, "R5 external", storageSel, 2);
    doFetch(8'h06, 1'b0);               // R5 boot ROM, R6 fixed bus mode
    chk(reqCount == fetchCount, "R2 one request per release", reqCount, fetchCount);
    chk(cfgQ.size() == 0, "R4 all loads seen", cfgQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule